// File: doc/BRIEF.md
# Status Packet Generator

This block turns a wide parallel status word into a short byte-serial packet on an 8-bit bus. It is one leaf of a status network: a control byte written into it picks the reporting behaviour, and a downstream collector pulls each packet out through a request/start handshake. Each packet opens with a fixed register-address byte that names the sender. The next byte carries a sequence tag and the two lowest status bits. The remaining status bits follow eight at a time, lowest first.

The control byte has two fields. Its upper two bits select the mode: halt, send a single report, or report automatically whenever the status word differs from the value last sent. Its lower six bits hold a tag that is placed in every packet, so that software can match a reply to the write that asked for it. Writing a mode other than halt queues a report at once.

The outgoing byte stream has no valid/ready pair. The request output plays the part of valid, and the start input plays the part of ready, but for the first byte only. After start is accepted, the sink must take one byte per cycle, because the stream cannot be back-pressured. While the request output is high, the address byte is held steady on the bus. The bus reads zero whenever nothing is offered or in flight.

Top module: `stat_pkt_gen`

## Requirements
- R1: A synchronous reset leaves the block idle: the request output is low, the byte bus is zero, the mode is halt and no report is pending.
- R2: A control write loads the mode from bits [7:6] (00 halt, 01 single, 10 automatic, 11 automatic) and the tag from bits [5:0]. Any non-halt write queues one report, so the request output is high in the next cycle unless a packet is still in flight.
- R3: Once high, the request output stays high until start is sampled high. Throughout that time the byte bus shows REG_ADDR (0x3C by default).
- R4: When start is sampled high with the request high at edge k, the remaining NBYTES-1 bytes appear in the cycles after edges k through k+NBYTES-2, one per cycle. The request output stays low over that span.
- R5: Byte 1 is {tag[5:0], status[1:0]}. The following bytes are status[9:2], status[17:10], status[25:18] and so on, with the top byte zero-padded. Each byte is taken from the status value present at the accepting edge.
- R6: In single mode, exactly one packet is sent per write. Later status changes raise no request.
- R7: In automatic mode (10 or 11), a status value that differs from the one in the last sent packet raises a new request.
- R8: A status change that happens while a packet is in flight is reported in a new packet. That packet is requested right after the current one ends.
- R9: A halt write cancels a report that has not yet started, and the request output is low in the next cycle. A packet already in flight runs to its end.
- R10: Start is ignored while the request output is low. The byte bus is zero when nothing is requested or in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control byte write enable |
| ctl_data | input | 8 | Control byte: mode [7:6], tag [5:0] |
| status_in | input | PAYLOAD_W | Parallel status word to report |
| pkt_start | input | 1 | Downstream accept of the address byte |
| pkt_req | output | 1 | A packet is offered |
| pkt_byte | output | 8 | Packet byte stream |

## Verification
The bench builds the block with its defaults: a 26-bit status word and address 0x3C. This gives five-byte packets in which the last byte is filled exactly, so every status bit lands in a byte position that the bench checks. With these values the bench can check a change made mid-packet, a halt that races a pending request, the alternate automatic encoding, and a reset that cuts a packet short. The zero-padding of a partly filled top byte appears only at other widths.

// File: rtl/stat_pkt_pkg.sv
package stat_pkt_pkg;
  // Reporting modes carried in control bits [7:6]
  typedef enum logic [1:0] {
    RPT_HALT   = 2'd0,
    RPT_SINGLE = 2'd1,
    RPT_AUTO   = 2'd2,
    RPT_AUTO2  = 2'd3
  } rpt_mode_e;

  localparam int TAG_W  = 6;
  localparam int BYTE_W = 8;

  function automatic logic is_auto(rpt_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/stat_pkt_ctrl.sv
module stat_pkt_ctrl
  import stat_pkt_pkg::*;
#(
  parameter int PAYLOAD_W = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_data,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic                 accept,
  output logic                 pending,
  output logic [TAG_W-1:0]     tag
);
  rpt_mode_e            mode_q;
  logic [PAYLOAD_W-1:0] last_sent_q;
  logic                 changed;

  // a difference from the last sent word counts only in automatic mode
  assign changed = is_auto(mode_q) && (status_in != last_sent_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= RPT_HALT;
      tag         <= '0;
      pending     <= 1'b0;
      last_sent_q <= '0;
    end else begin
      if (ctl_we) begin
        mode_q <= rpt_mode_e'(ctl_data[7:6]);
        tag    <= ctl_data[TAG_W-1:0];
      end
      if (accept) last_sent_q <= status_in;
      // a write has priority: non-halt queues a report, halt cancels it
      if (ctl_we)       pending <= (ctl_data[7:6] != RPT_HALT);
      else if (accept)  pending <= 1'b0;
      else if (changed) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/stat_pkt_shift.sv
module stat_pkt_shift
  import stat_pkt_pkg::*;
#(
  parameter int         PAYLOAD_W = 26,
  parameter logic [7:0] REG_ADDR  = 8'h3C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pending,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic [TAG_W-1:0]     tag,
  input  logic                 pkt_start,
  output logic                 accept,
  output logic                 pkt_req,
  output logic [7:0]           pkt_byte
);
  localparam int HI_W   = PAYLOAD_W - 2;
  localparam int NBYTES = 2 + (HI_W + BYTE_W - 1) / BYTE_W;
  localparam int BODY_W = (NBYTES - 1) * BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);

  logic [BODY_W-1:0] body;
  logic [BODY_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy;

  // bytes 1..NBYTES-1, lowest byte first
  always_comb begin
    body              = '0;
    body[BYTE_W-1:0]  = {tag, status_in[1:0]};
    for (int i = 0; i < HI_W; i++) body[BYTE_W + i] = status_in[2 + i];
  end

  assign busy     = (left_q != '0);
  assign pkt_req  = pending && !busy;
  assign accept   = pkt_req && pkt_start;
  assign pkt_byte = busy ? sh_q[BYTE_W-1:0] : (pkt_req ? REG_ADDR : 8'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (accept) begin
      sh_q   <= body;
      left_q <= CNT_W'(NBYTES - 1);
    end else if (busy) begin
      sh_q   <= sh_q >> BYTE_W;
      left_q <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/stat_pkt_gen.sv
module stat_pkt_gen
  import stat_pkt_pkg::*;
#(
  parameter int         PAYLOAD_W = 26,
  parameter logic [7:0] REG_ADDR  = 8'h3C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_data,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic                 pkt_start,
  output logic                 pkt_req,
  output logic [7:0]           pkt_byte
);
  logic             pending;
  logic             accept;
  logic [TAG_W-1:0] tag;

  stat_pkt_ctrl #(.PAYLOAD_W(PAYLOAD_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .status_in(status_in), .accept(accept), .pending(pending), .tag(tag)
  );

  stat_pkt_shift #(.PAYLOAD_W(PAYLOAD_W), .REG_ADDR(REG_ADDR)) u_shift (
    .clk(clk), .rst(rst), .pending(pending), .status_in(status_in),
    .tag(tag), .pkt_start(pkt_start), .accept(accept),
    .pkt_req(pkt_req), .pkt_byte(pkt_byte)
  );
endmodule

// File: rtl/stat_pkt_gen_chk.sv
module stat_pkt_gen_chk #(
  parameter int         PAYLOAD_W = 26,
  parameter logic [7:0] REG_ADDR  = 8'h3C
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ctl_we,
  input logic [7:0]           ctl_data,
  input logic [PAYLOAD_W-1:0] status_in,
  input logic                 pkt_start,
  input logic                 pkt_req,
  input logic [7:0]           pkt_byte
);
  AST_RST_IDLE: assert property (@(posedge clk) rst |=> (!pkt_req && pkt_byte == 8'h00)); // R1
  AST_REQ_ADDR: assert property (@(posedge clk) disable iff (rst) pkt_req |-> pkt_byte == REG_ADDR); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pkt_req && !pkt_start && !(ctl_we && ctl_data[7:6] == 2'b00)) |=> pkt_req); // R3
  AST_SEND_QUIET: assert property (@(posedge clk) disable iff (rst) (pkt_req && pkt_start) |=> !pkt_req); // R4
  AST_BYTE1_LOW: assert property (@(posedge clk) disable iff (rst)
    (pkt_req && pkt_start) |=> pkt_byte[1:0] == $past(status_in[1:0])); // R5
  AST_HALT_DROP: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_data[7:6] == 2'b00) |=> !pkt_req); // R9
endmodule

bind stat_pkt_gen stat_pkt_gen_chk #(.PAYLOAD_W(PAYLOAD_W), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/stat_pkt_gen_tb.sv
module stat_pkt_gen_tb;
  localparam int         PW = 26;
  localparam logic [7:0] RA = 8'h3C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_data = '0;
  logic [PW-1:0] status_in = '0;
  logic          pkt_start = 1'b0;
  logic          pkt_req;
  logic [7:0]    pkt_byte;

  int    n_run = 0;
  int    n_fail = 0;
  string tag_s = "R1";
  bit    live = 0;
  bit    done = 0;

  always #10 clk = ~clk;

  stat_pkt_gen u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .status_in(status_in), .pkt_start(pkt_start),
    .pkt_req(pkt_req), .pkt_byte(pkt_byte)
  );

  // behavioural reference
  int         m_mode = 0;
  logic [5:0] m_tag = '0;
  bit         m_pend = 0;
  logic [PW-1:0] m_last = '0;
  logic [7:0] m_q[$];

  function automatic bit exp_req();
    return m_pend && (m_q.size() == 0);
  endfunction
  function automatic logic [7:0] exp_byte();
    if (m_q.size() != 0) return m_q[0];
    return exp_req() ? RA : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_tag = '0; m_pend = 0; m_last = '0; m_q.delete();
    end else begin
      bit acc, chg;
      acc = exp_req() && pkt_start;
      chg = (m_mode >= 2) && (status_in != m_last);
      if (m_q.size() != 0) void'(m_q.pop_front());
      if (acc) begin
        m_q.push_back({m_tag, status_in[1:0]});
        m_q.push_back(status_in[9:2]);
        m_q.push_back(status_in[17:10]);
        m_q.push_back(status_in[25:18]);
        m_last = status_in;
      end
      if (ctl_we)   m_pend = (ctl_data[7:6] != 2'b00);
      else if (acc) m_pend = 0;
      else if (chg) m_pend = 1;
      if (ctl_we) begin
        m_mode = int'(ctl_data[7:6]);
        m_tag  = ctl_data[5:0];
      end
    end
    live = 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (live && !done) begin
      chk(tag_s, {31'd0, pkt_req}, {31'd0, exp_req()});
      chk(tag_s, {24'd0, pkt_byte}, {24'd0, exp_byte()});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_data = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 50 && !pkt_req; i++) @(negedge clk);
  endtask

  task automatic ack();
    pkt_start = 1'b1; @(negedge clk); pkt_start = 1'b0;
  endtask

  initial begin
    logic [PW-1:0] v;
    tick(3);
    @(negedge clk); rst = 1'b0;
    tag_s = "R1";
    chk("R1", {31'd0, pkt_req}, 32'd0);
    chk("R1", {24'd0, pkt_byte}, 32'd0);

    // single report with delayed accept
    tag_s = "R2";
    v = 26'h3A5C3E1; status_in = v;
    wr(8'h45);
    chk("R2", {31'd0, pkt_req}, 32'd1);
    tag_s = "R3";
    tick(3);
    chk("R3", {31'd0, pkt_req}, 32'd1);
    chk("R3", {24'd0, pkt_byte}, {24'd0, RA});
    tag_s = "R4";
    ack();
    chk("R5", {24'd0, pkt_byte}, {24'd0, 6'h05, v[1:0]});
    chk("R4", {31'd0, pkt_req}, 32'd0);
    tick(1); chk("R5", {24'd0, pkt_byte}, {24'd0, v[9:2]});
    tick(1); chk("R5", {24'd0, pkt_byte}, {24'd0, v[17:10]});
    tick(1); chk("R5", {24'd0, pkt_byte}, {24'd0, v[25:18]});
    tick(1); chk("R10", {24'd0, pkt_byte}, 32'd0);
    tag_s = "R6";
    status_in = 26'h0123456;
    tick(4);
    chk("R6", {31'd0, pkt_req}, 32'd0);

    // start with nothing offered
    tag_s = "R10";
    pkt_start = 1'b1; tick(3); pkt_start = 1'b0;
    chk("R10", {31'd0, pkt_req}, 32'd0);
    chk("R10", {24'd0, pkt_byte}, 32'd0);

    // automatic reporting
    tag_s = "R7";
    wr(8'h89);
    wait_req(); ack(); tick(5);
    chk("R7", {31'd0, pkt_req}, 32'd0);
    status_in = 26'h2000001; tick(2);
    chk("R7", {31'd0, pkt_req}, 32'd1);

    // change while a packet is in flight
    tag_s = "R8";
    ack(); tick(1);
    status_in = 26'h1555555; tick(1);
    chk("R8", {31'd0, pkt_req}, 32'd0);
    tick(3);
    chk("R8", {31'd0, pkt_req}, 32'd1);

    // halt cancels the unstarted report
    tag_s = "R9";
    wr(8'h00);
    chk("R9", {31'd0, pkt_req}, 32'd0);
    status_in = 26'h0FFFFFF; tick(4);
    chk("R9", {31'd0, pkt_req}, 32'd0);

    // alternate automatic encoding
    tag_s = "R7";
    wr(8'hC1);
    wait_req(); ack(); tick(5);
    status_in = 26'h0000002; tick(2);
    chk("R7", {31'd0, pkt_req}, 32'd1);
    ack(); tick(6);

    // reset in mid-packet
    tag_s = "R1";
    status_in = 26'h0000003; tick(2);
    wait_req(); ack(); tick(1);
    rst = 1'b1; tick(1); rst = 1'b0;
    chk("R1", {31'd0, pkt_req}, 32'd0);
    chk("R1", {24'd0, pkt_byte}, 32'd0);
    tick(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule